// File: doc/BRIEF.md
# Memory type range resolver

This block answers one question per request: which caching type applies to a given physical address. Three sources decide the answer, in order of priority. A table of 88 small-granule entries covers the first megabyte. A bank of base/mask range entries covers the rest of the address space. A default type applies when no range entry claims the address. Software-style configuration arrives through a simple register-write port. It loads the low-memory table one byte at a time, the base and mask word of each range entry, a control word and an optional upper-memory limit.

A lookup is a valid/ready request carrying one address. The answer is returned as a registered type code with its own valid/ready pair. When the low-memory table applies, the answer comes from a single block-RAM read. Otherwise the range entries are examined one per clock, and overlapping matches are folded together as the scan goes. The scan stops early once the combined result can only be uncached. While a lookup is in flight or an answer waits to be taken, no new request is accepted.

Top module: `memtype_resolver`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, and the control word is cleared, so the first lookup returns the invalid code 0xFF.
- R2: When control bit 11 (global enable) is 0, every lookup returns 0xFF, whatever the tables hold.
- R3: With HAS_FIXED set, control bit 10 (low-table enable) set and the address below 0x100000, the result is the low-table byte at index addr[19:16] for addresses below 0x80000, 8 + addr[17:14] for 0x80000 to 0xBFFFF, and 24 + addr[17:12] for 0xC0000 to 0xFFFFF. Range entries and the default are not consulted.
- R4: With control bit 10 clear, addresses below 0x100000 are resolved through the range entries and the default, like any other address.
- R5: A range entry takes part only while bit 11 of its mask word is 1. It matches when (addr & mask) equals (base & mask), with bits 11:0 of address, base and mask ignored. Its type is bits 7:0 of its base word.
- R6: Type codes are uncached 0, write-combining 1, write-through 4, write-protect 5, write-back 6 and invalid 0xFF. Matches are folded in entry order. Uncached with anything gives uncached. Write-back with write-through, in either order, gives write-through. Equal types stay unchanged. Any other pair gives uncached.
- R7: When no enabled range entry matches, the result is the default type held in control bits 7:0.
- R8: A write to the upper-memory limit stores the value with bits 22:0 cleared. When the limit is non-zero, a lookup resolved on the range path whose address is at least 0x1_0000_0000 and below the limit returns write-back (6).
- R9: req_ready is 0 from the accepting edge until the response has been taken. While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_type stays unchanged.
- R10: On the write port, cfg_kind 0 writes low-table byte cfg_idx (0 to 87) from cfg_wdata[7:0]. Kind 1 writes the base word of range entry cfg_idx and kind 2 writes its mask word. Kind 3 writes the control word from cfg_wdata[11:0], and kind 4 writes the upper-memory limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Selects which configuration item is written |
| cfg_idx | input | 7 | Low-table byte index or range entry index |
| cfg_wdata | input | ADDR_W | Write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_addr | input | ADDR_W | Physical address to resolve |
| rsp_valid | output | 1 | Resolved type valid |
| rsp_ready | input | 1 | Consumer takes the resolved type |
| rsp_type | output | 8 | Resolved type code |

## Verification
The bench probes the last entry and the start of each granule region of the low table. An off-by-one region decode would return a neighbouring byte there. It toggles the low-table enable over a range entry that covers the same address, which shows whether the table wrongly shadows the ranges or is skipped. Overlapping ranges are tried in both write-back/write-through orders and against write-combining and uncached partners. A fold that is not symmetric, or that lets the first match stand, returns the wrong code. The upper limit is probed just below and exactly at its masked value, so a design that keeps the unmasked low bits answers write-back where uncached is due.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

  localparam logic [7:0] MT_UC  = 8'h00;
  localparam logic [7:0] MT_WC  = 8'h01;
  localparam logic [7:0] MT_WT  = 8'h04;
  localparam logic [7:0] MT_WP  = 8'h05;
  localparam logic [7:0] MT_WB  = 8'h06;
  localparam logic [7:0] MT_INV = 8'hFF;

  localparam int FIX_ENTRIES = 88;
  localparam int FIX_IDX_W   = 7;

  localparam logic [2:0] CFG_FIXED = 3'd0;
  localparam logic [2:0] CFG_VBASE = 3'd1;
  localparam logic [2:0] CFG_VMASK = 3'd2;
  localparam logic [2:0] CFG_CTRL  = 3'd3;
  localparam logic [2:0] CFG_TOM2  = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_FIX, ST_SCAN} rslv_state_t;

  // Fold two matching range types into one.
  function automatic logic [7:0] mt_merge(input logic [7:0] a, input logic [7:0] b);
    if (a == MT_UC || b == MT_UC)                                 return MT_UC;
    if ((a == MT_WB && b == MT_WT) || (a == MT_WT && b == MT_WB)) return MT_WT;
    if (a != b)                                                   return MT_UC;
    return a;
  endfunction

endpackage

// File: rtl/mt_fixed_table.sv
module mt_fixed_table
  import memtype_pkg::*;
(
  input  logic                 clk,
  input  logic                 we,
  input  logic [FIX_IDX_W-1:0] waddr,
  input  logic [7:0]           wdata,
  input  logic [19:0]          look_addr,
  output logic [7:0]           rdata
);

  logic [7:0]           mem [FIX_ENTRIES];
  logic [FIX_IDX_W-1:0] ridx;

  // Region decode: 64 KiB, 16 KiB, then 4 KiB granules.
  always_comb begin
    if (!look_addr[19])
      ridx = {4'd0, look_addr[18:16]};
    else if (look_addr[19:18] == 2'b10)
      ridx = 7'd8 + {3'd0, look_addr[17:14]};
    else
      ridx = 7'd24 + {1'b0, look_addr[17:12]};
  end

  always_ff @(posedge clk) begin
    if (we && (waddr < FIX_IDX_W'(FIX_ENTRIES)))
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[ridx];
  end

endmodule

// File: rtl/mt_var_bank.sv
module mt_var_bank #(
  parameter int ADDR_W  = 40,
  parameter int NUM_VAR = 4,
  localparam int IDX_W  = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic              mask_we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [IDX_W-1:0]  sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [7:0]        hit_type
);

  localparam logic [ADDR_W-1:0] PAGE_KEEP = ~ADDR_W'(12'hFFF);

  logic [ADDR_W-1:0] base_q [NUM_VAR];
  logic [ADDR_W-1:0] mask_q [NUM_VAR];

  for (genvar g = 0; g < NUM_VAR; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        mask_q[g] <= '0;
      end else begin
        if (base_we && widx == IDX_W'(g)) base_q[g] <= wdata;
        if (mask_we && widx == IDX_W'(g)) mask_q[g] <= wdata;
      end
    end
  end

  logic [ADDR_W-1:0] sel_base, sel_mask;
  assign sel_base = base_q[sel];
  assign sel_mask = mask_q[sel];
  assign hit_type = sel_base[7:0];
  assign hit      = sel_mask[11] &&
                    (((addr ^ sel_base) & sel_mask & PAGE_KEEP) == '0);

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int ADDR_W    = 40,
  parameter int NUM_VAR   = 4,
  parameter bit HAS_FIXED = 1'b1,
  parameter bit HAS_TOM2  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_kind,
  input  logic [6:0]        cfg_idx,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_type
);

  localparam int IDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(NUM_VAR - 1);
  localparam logic [ADDR_W-1:0] FOUR_GIB  = ADDR_W'(1) << 32;
  localparam logic [ADDR_W-1:0] TOM2_KEEP = ~ADDR_W'(23'h7F_FFFF);

  rslv_state_t       state;
  logic [11:0]       ctl_q;
  logic [ADDR_W-1:0] tom2_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  scan_idx;
  logic [7:0]        acc_q;
  logic              acc_vld;

  logic glob_en, fix_en;
  assign glob_en = ctl_q[11];
  assign fix_en  = ctl_q[10];

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      tom2_q <= '0;
    end else if (cfg_we) begin
      if (cfg_kind == CFG_CTRL) ctl_q <= cfg_wdata[11:0];
      if (cfg_kind == CFG_TOM2 && HAS_TOM2) tom2_q <= cfg_wdata & TOM2_KEEP;
    end
  end

  // Low-memory table
  logic [7:0] fix_rdata;
  if (HAS_FIXED) begin : g_fixed
    mt_fixed_table u_fixed (
      .clk       (clk),
      .we        (cfg_we && cfg_kind == CFG_FIXED),
      .waddr     (cfg_idx),
      .wdata     (cfg_wdata[7:0]),
      .look_addr (req_addr[19:0]),
      .rdata     (fix_rdata)
    );
  end else begin : g_nofixed
    assign fix_rdata = MT_INV;
  end

  // Range entry bank
  logic       idx_ok, vb_hit;
  logic [7:0] vb_type;
  assign idx_ok = ({25'd0, cfg_idx} < NUM_VAR);

  mt_var_bank #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_var (
    .clk      (clk),
    .rst      (rst),
    .base_we  (cfg_we && idx_ok && cfg_kind == CFG_VBASE),
    .mask_we  (cfg_we && idx_ok && cfg_kind == CFG_VMASK),
    .widx     (cfg_idx[IDX_W-1:0]),
    .wdata    (cfg_wdata),
    .sel      (scan_idx),
    .addr     (addr_q),
    .hit      (vb_hit),
    .hit_type (vb_type)
  );

  // Scan datapath
  logic       accept, fix_path, scan_stop, tom2_hit;
  logic [7:0] merged, picked, final_type;

  assign req_ready = (state == ST_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign fix_path  = HAS_FIXED && fix_en && (req_addr[ADDR_W-1:20] == '0);

  always_comb begin
    merged    = acc_vld ? mt_merge(acc_q, vb_type) : vb_type;
    scan_stop = (vb_hit && merged == MT_UC) || (scan_idx == LAST_IDX);
    picked    = vb_hit ? merged : (acc_vld ? acc_q : ctl_q[7:0]);
    tom2_hit  = HAS_TOM2 && (tom2_q != '0) && (addr_q >= FOUR_GIB) && (addr_q < tom2_q);
    final_type = tom2_hit ? MT_WB : picked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_type  <= '0;
      addr_q    <= '0;
      scan_idx  <= '0;
      acc_q     <= '0;
      acc_vld   <= 1'b0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          addr_q   <= req_addr;
          scan_idx <= '0;
          acc_vld  <= 1'b0;
          if (!glob_en) begin
            rsp_type  <= MT_INV;
            rsp_valid <= 1'b1;
          end else if (fix_path) begin
            state <= ST_FIX;
          end else begin
            state <= ST_SCAN;
          end
        end
        ST_FIX: begin
          rsp_type  <= fix_rdata;
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_SCAN: begin
          if (vb_hit) begin
            acc_q   <= merged;
            acc_vld <= 1'b1;
          end
          if (scan_stop) begin
            rsp_type  <= final_type;
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            scan_idx <= scan_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_type)); // R9
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    accept |=> !req_ready); // R9
  AST_DISABLED_INVALID: assert property (@(posedge clk) disable iff (rst)
    accept && !glob_en |=> rsp_valid && rsp_type == MT_INV); // R2
  AST_FIXED_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    state == ST_FIX |=> rsp_valid && state == ST_IDLE); // R3
  AST_UC_EARLY_STOP: assert property (@(posedge clk) disable iff (rst)
    state == ST_SCAN && vb_hit && vb_type == MT_UC |=> state == ST_IDLE && rsp_valid); // R6

endmodule

// File: tb/tb_memtype_resolver.sv
`timescale 1ns/1ps
module tb_memtype_resolver;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [2:0]  cfg_kind;
  logic [6:0]  cfg_idx;
  logic [39:0] cfg_wdata;
  logic        req_valid;
  logic        req_ready;
  logic [39:0] req_addr;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [7:0]  rsp_type;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  memtype_resolver dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type)
  );

  localparam logic [39:0] M_1MIB   = 40'hFF_FFF0_0800;
  localparam logic [39:0] M_256MIB = 40'hFF_F000_0800;
  localparam logic [39:0] M_128MIB = 40'hFF_F800_0800;

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] kind, input logic [6:0] idx, input logic [39:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [39:0] a, input logic [7:0] exp, input string req);
    int w;
    @(negedge clk);
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!rsp_valid && w < 100) begin @(negedge clk); w++; end
    chk({req, " valid"}, 40'(rsp_valid), 40'd1);
    chk(req, 40'(rsp_type), 40'(exp));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready after reset", 40'(req_ready), 40'd1);
    chk("R1 rsp_valid after reset", 40'(rsp_valid), 40'd0);
    lookup(40'h0000_1000, 8'hFF, "R1 control cleared gives invalid");
  endtask

  task automatic t_fixed;   // R10 kind 0/1/2/3 encodings used here
    cfg(3'd0, 7'd0,  40'h00);
    cfg(3'd0, 7'd3,  40'h05);
    cfg(3'd0, 7'd8,  40'h04);
    cfg(3'd0, 7'd13, 40'h01);
    cfg(3'd0, 7'd24, 40'h06);
    cfg(3'd0, 7'd87, 40'h04);
    cfg(3'd1, 7'd0,  40'h0000_0001);
    cfg(3'd2, 7'd0,  M_1MIB);
    cfg(3'd3, 7'd0,  40'hC06);
    lookup(40'h0003_0000, 8'h05, "R3 64K region idx3");
    lookup(40'h0000_F000, 8'h00, "R3 64K region idx0");
    lookup(40'h0008_0000, 8'h04, "R3 16K region start idx8");
    lookup(40'h0009_4000, 8'h01, "R3 16K region idx13");
    lookup(40'h000C_0000, 8'h06, "R3 4K region start idx24");
    lookup(40'h000F_F000, 8'h04, "R3 4K region last idx87");
    lookup(40'h0020_0000, 8'h06, "R7 above 1MiB default");
  endtask

  task automatic t_fixed_off;
    cfg(3'd3, 7'd0, 40'h806);
    lookup(40'h0003_0000, 8'h01, "R4 low table disabled uses range");
    lookup(40'h0030_0000, 8'h06, "R7 no match gives default");
    cfg(3'd3, 7'd0, 40'h406);
    lookup(40'h0003_0000, 8'hFF, "R2 global enable clear");
    lookup(40'h0030_0000, 8'hFF, "R2 global enable clear high");
  endtask

  task automatic t_var_enable;
    cfg(3'd3, 7'd0, 40'h806);
    cfg(3'd2, 7'd0, 40'hFF_FFF0_0000);
    lookup(40'h0003_0000, 8'h06, "R5 entry with mask bit11 clear ignored");
    cfg(3'd1, 7'd1, 40'h00_4000_0F00);
    cfg(3'd2, 7'd1, 40'hFF_F000_0000);
    lookup(40'h0040_0000_0ABC & 40'hFF_FFFF_FFFF, 8'h06, "R5 disabled entry");
    cfg(3'd2, 7'd1, M_256MIB);
    lookup(40'h00_4000_0ABC, 8'h00, "R5 match ignores low 12 bits");
    lookup(40'h00_5000_0000, 8'h06, "R5 outside range");
  endtask

  task automatic t_overlap;
    cfg(3'd1, 7'd1, 40'h00_4000_0006);
    cfg(3'd1, 7'd2, 40'h00_4000_0004);
    cfg(3'd2, 7'd2, M_128MIB);
    lookup(40'h00_4000_1000, 8'h04, "R6 WB then WT gives WT");
    lookup(40'h00_4800_0000, 8'h06, "R6 single match WB");
    cfg(3'd1, 7'd2, 40'h00_4000_0001);
    lookup(40'h00_4000_1000, 8'h00, "R6 WB with WC gives UC");
    cfg(3'd1, 7'd2, 40'h00_4000_0006);
    lookup(40'h00_4000_1000, 8'h06, "R6 equal types kept");
    cfg(3'd1, 7'd2, 40'h00_4000_0000);
    lookup(40'h00_4000_1000, 8'h00, "R6 UC wins");
    cfg(3'd1, 7'd1, 40'h00_4000_0004);
    cfg(3'd1, 7'd2, 40'h00_4000_0006);
    lookup(40'h00_4000_1000, 8'h04, "R6 WT then WB gives WT");
  endtask

  task automatic t_tom2;   // R10 kind 4
    cfg(3'd2, 7'd1, 40'h0);
    cfg(3'd2, 7'd2, 40'h0);
    cfg(3'd3, 7'd0, 40'h800);
    lookup(40'h01_0000_0000, 8'h00, "R8 limit zero no override");
    cfg(3'd4, 7'd0, 40'h01_2345_6789);
    lookup(40'h01_0000_0000, 8'h06, "R8 at 4GiB forced WB");
    lookup(40'h01_22FF_F000, 8'h06, "R8 just below limit");
    lookup(40'h01_2300_0000, 8'h00, "R8 at masked limit not forced");
    lookup(40'h00_FFFF_F000, 8'h00, "R8 below 4GiB not forced");
  endtask

  task automatic t_handshake;
    logic [7:0] held;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 40'h00_0000_5000;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 not ready during scan", 40'(req_ready), 40'd0);
    while (!rsp_valid) @(negedge clk);
    held = rsp_type;
    repeat (2) @(negedge clk);
    chk("R9 rsp held valid", 40'(rsp_valid), 40'd1);
    chk("R9 rsp type stable", 40'(rsp_type), 40'(held));
    chk("R9 not ready while rsp pending", 40'(req_ready), 40'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R9 rsp cleared after take", 40'(rsp_valid), 40'd0);
    chk("R9 ready after take", 40'(req_ready), 40'd1);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_kind = '0; cfg_idx = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; rsp_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_fixed_off();
    t_var_enable();
    t_overlap();
    t_tom2();
    t_handshake();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule